// File: doc/BRIEF.md
# Strobe Skew Estimator from Phase-Detector Statistics

Two sampling strobes reach a measurement site over separate routes, and the difference in their arrival times must be known before paired samples can be interpreted. A pair of flip-flop phase detectors sits at that site. Detector A reports 1 when strobe B lands later than strobe A. Detector B reports the opposite ordering. An external controller sweeps the programmed delay between the strobes through a rising series of step indices and fires the strobes many times at each step. This block receives every detector reading and estimates the skew without using a divider.

For each step the block counts the readings and the ones seen on each detector. A step is complete on the reading that brings its count to the programmed repetition number. At that point each detector is classed as high or low by comparing twice its ones count with the repetition number. The first complete step after a start sets a reference class for each detector. The first later step whose class differs from that reference marks the detector's 50 percent crossing, and its index is latched. When the sweep ends, the block reports the sum of the two crossing indices. This sum is the midpoint of the two crossings in half-step units. A flag shows when either detector failed to cross.

The estimate is only as good as the match between the setup times of the two detector flip-flops. Any mismatch between them appears directly as a skew offset.

Top module: `skew_tally`

## Requirements
- R1: After reset, and one cycle after `start`, `done` is 0, `no_cross` is 1 and `cross_a`, `cross_b` and `skew_half` are 0.
- R2: A step completes on the valid reading that makes the step's reading count equal `reps`. A detector is high for that step when 2 × (its ones) ≥ `reps`, so an exact half counts as high.
- R3: The first step to complete after start or reset sets each detector's reference class. A detector's crossing is the index of the first later completed step whose class differs from its reference. The two detectors are judged independently.
- R4: Once a crossing is latched it keeps its value until the next `start`, whatever later steps show.
- R5: A valid reading whose `step_idx` differs from the current step's index begins a new step and clears the tallies. A step left with fewer than `reps` readings never completes.
- R6: Readings beyond `reps` at the same step index are ignored.
- R7: `done` rises one cycle after `sweep_end` and holds until `start`. While `done` is high, readings are ignored. `skew_half` always equals `cross_a` + `cross_b`, the midpoint in half-step units.
- R8: `no_cross` is 1 whenever at least one detector has no latched crossing, and 0 once both have one.
- R9: With `reps` = 1, every single reading is a complete step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears all state for a new sweep |
| sweep_end | input | 1 | Closes the sweep and sets `done` |
| smp_valid | input | 1 | A detector reading is present |
| pd_a | input | 1 | Detector A bit: strobe B later than strobe A |
| pd_b | input | 1 | Detector B bit: strobe A later than strobe B |
| step_idx | input | IDXW | Offset step index of the reading |
| reps | input | CNTW | Readings per step |
| cross_a | output | IDXW | Latched crossing index of detector A |
| cross_b | output | IDXW | Latched crossing index of detector B |
| skew_half | output | IDXW+1 | Skew estimate in half-step units |
| no_cross | output | 1 | At least one detector has not crossed |
| done | output | 1 | Sweep closed, results final |

## Verification
A wrong tally or a wrong reference class has no effect on any output until the completed step that should have crossed, or should not have crossed. At that step the fault shows as a wrong `cross_a` or `cross_b` on the following cycle. The bench therefore reads both crossings after every step of the sweep, so a fault is caught at the first step where it matters. It also places an exact-half tie and a reversal after the crossing, and checks that each leaves the latched index unchanged. A wrongly handled step boundary, such as a partial step that completes or extra readings that are counted, shows either as a crossing at the wrong index or as `no_cross` in the wrong state once `done` rises.

// File: rtl/skew_tally.sv
module skew_tally #(
  parameter int IDXW = 6,
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            sweep_end,
  input  logic            smp_valid,
  input  logic            pd_a,
  input  logic            pd_b,
  input  logic [IDXW-1:0] step_idx,
  input  logic [CNTW-1:0] reps,
  output logic [IDXW-1:0] cross_a,
  output logic [IDXW-1:0] cross_b,
  output logic [IDXW:0]   skew_half,
  output logic            no_cross,
  output logic            done
);
  localparam int SKW = IDXW + 1;

  logic [IDXW-1:0] cur_idx;
  logic            have_step, step_done;
  logic [CNTW-1:0] n_cnt, ones_a, ones_b;
  logic            ref_valid, ref_a, ref_b, found_a, found_b;

  logic            new_step, take, fin, lvl_a, lvl_b;
  logic [CNTW-1:0] n_nx, oa_nx, ob_nx;

  assign new_step = !have_step || (step_idx != cur_idx);
  assign take     = smp_valid && !done && (new_step || !step_done);
  assign n_nx     = new_step ? CNTW'(1) : n_cnt + CNTW'(1);
  assign oa_nx    = new_step ? CNTW'(pd_a) : ones_a + CNTW'(pd_a);
  assign ob_nx    = new_step ? CNTW'(pd_b) : ones_b + CNTW'(pd_b);
  assign fin      = take && (n_nx == reps);
  assign lvl_a    = {oa_nx, 1'b0} >= {1'b0, reps};
  assign lvl_b    = {ob_nx, 1'b0} >= {1'b0, reps};

  assign no_cross  = !(found_a && found_b);
  assign skew_half = SKW'(cross_a) + SKW'(cross_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx <= '0; have_step <= 1'b0; step_done <= 1'b0;
      n_cnt <= '0; ones_a <= '0; ones_b <= '0;
      ref_valid <= 1'b0; ref_a <= 1'b0; ref_b <= 1'b0;
      found_a <= 1'b0; found_b <= 1'b0;
      cross_a <= '0; cross_b <= '0; done <= 1'b0;
    end else if (start) begin
      cur_idx <= '0; have_step <= 1'b0; step_done <= 1'b0;
      n_cnt <= '0; ones_a <= '0; ones_b <= '0;
      ref_valid <= 1'b0; ref_a <= 1'b0; ref_b <= 1'b0;
      found_a <= 1'b0; found_b <= 1'b0;
      cross_a <= '0; cross_b <= '0; done <= 1'b0;
    end else begin
      if (sweep_end) done <= 1'b1;
      if (take) begin
        have_step <= 1'b1;
        cur_idx   <= step_idx;
        n_cnt     <= n_nx;
        ones_a    <= oa_nx;
        ones_b    <= ob_nx;
        step_done <= fin;
        if (fin) begin
          if (!ref_valid) begin
            ref_valid <= 1'b1;
            ref_a     <= lvl_a;
            ref_b     <= lvl_b;
          end else begin
            if (!found_a && lvl_a != ref_a) begin
              found_a <= 1'b1;
              cross_a <= step_idx;
            end
            if (!found_b && lvl_b != ref_b) begin
              found_b <= 1'b1;
              cross_b <= step_idx;
            end
          end
        end
      end
    end
  end

  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && no_cross && cross_a == '0 && cross_b == '0));

  p_ones_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    have_step |-> (ones_a <= n_cnt && ones_b <= n_cnt));

  p_found_needs_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (found_a || found_b) |-> ref_valid);

  p_cross_a_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (found_a && !start) |=> (found_a && $stable(cross_a)));

  p_cross_b_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (found_b && !start) |=> (found_b && $stable(cross_b)));

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_done_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(n_cnt) && $stable(ones_a) && $stable(ones_b)));
endmodule

// File: tb/tb_skew_tally.sv
module tb_skew_tally;
  localparam int IDXW = 6;
  localparam int CNTW = 8;
  localparam int NSTEP = 10;
  localparam logic [7:0] TBL [NSTEP] = '{8'h80, 8'h80, 8'h70, 8'h61, 8'h42,
                                         8'h33, 8'h15, 8'h08, 8'h58, 8'h08};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sweep_end = 1'b0;
  logic smp_valid = 1'b0, pd_a = 1'b0, pd_b = 1'b0;
  logic [IDXW-1:0] step_idx = '0;
  logic [CNTW-1:0] reps = '0;
  logic [IDXW-1:0] cross_a, cross_b;
  logic [IDXW:0]   skew_half;
  logic            no_cross, done;

  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  skew_tally #(.IDXW(IDXW), .CNTW(CNTW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sweep_end(sweep_end),
    .smp_valid(smp_valid), .pd_a(pd_a), .pd_b(pd_b), .step_idx(step_idx),
    .reps(reps), .cross_a(cross_a), .cross_b(cross_b), .skew_half(skew_half),
    .no_cross(no_cross), .done(done));

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic run_step(input int idx, input int n, input int ka, input int kb);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      step_idx  = IDXW'(idx);
      pd_a = (j < ka);
      pd_b = (j < kb);
    end
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk); sweep_end = 1'b1;
    @(negedge clk); sweep_end = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ref_a, ref_b, xa, xb;
    bit fa, fb;
    repeat (3) @(negedge clk);
    check("R1 reset done", done, 0);
    check("R1 reset no_cross", no_cross, 1);
    check("R1 reset cross_a", cross_a, 0);
    check("R1 reset skew", skew_half, 0);
    rst_n = 1'b1;

    // Table sweep: R2 tie is high, R3 crossings, R4 reversal ignored
    reps = 8;
    pulse_start();
    ref_a = 0; ref_b = 0; xa = 0; xb = 0; fa = 0; fb = 0;
    for (int i = 0; i < NSTEP; i++) begin
      int ka, kb, la, lb;
      ka = TBL[i][7:4];
      kb = TBL[i][3:0];
      la = (2 * ka >= 8);
      lb = (2 * kb >= 8);
      run_step(2 * i + 1, 8, ka, kb);
      if (i == 0) begin
        ref_a = la; ref_b = lb;
      end else begin
        if (!fa && la != ref_a) begin fa = 1; xa = 2 * i + 1; end
        if (!fb && lb != ref_b) begin fb = 1; xb = 2 * i + 1; end
      end
      check("R3 R4 cross_a per step", cross_a, xa);
      check("R3 R4 cross_b per step", cross_b, xb);
    end
    check("R2 tie high so cross_a at 11", xa, 11);
    pulse_end();
    check("R7 done after sweep_end", done, 1);
    check("R7 skew midpoint", skew_half, 24);
    check("R8 both crossed", no_cross, 0);

    // R7: readings ignored while done
    run_step(40, 8, 0, 8);
    check("R7 cross_a frozen when done", cross_a, 11);
    check("R7 done holds", done, 1);
    pulse_start();
    check("R1 start clears done", done, 0);
    check("R1 start clears cross_a", cross_a, 0);
    check("R1 start clears no_cross", no_cross, 1);

    // R5: partial step never completes; new index resets tallies
    run_step(0, 8, 8, 0);
    run_step(1, 3, 0, 0);
    check("R5 partial step no crossing", cross_a, 0);
    run_step(2, 8, 8, 0);
    check("R5 reset tallies, still high", cross_a, 0);
    run_step(3, 8, 0, 0);
    check("R5 cross_a at step 3", cross_a, 3);
    pulse_end();
    check("R8 detector B never crossed", no_cross, 1);
    check("R7 skew with one missing", skew_half, 3);

    // R6: extra readings at the same index ignored
    pulse_start();
    run_step(0, 8, 8, 8);
    run_step(1, 8, 8, 8);
    run_step(1, 8, 0, 0);
    check("R6 extra readings ignored a", cross_a, 0);
    check("R6 extra readings ignored b", cross_b, 0);
    pulse_end();
    check("R6 R8 no crossing", no_cross, 1);

    // R9: reps of one
    pulse_start();
    reps = 1;
    run_step(0, 1, 0, 1);
    run_step(1, 1, 1, 1);
    run_step(2, 1, 1, 0);
    pulse_end();
    check("R9 cross_a", cross_a, 1);
    check("R9 cross_b", cross_b, 2);
    check("R9 skew", skew_half, 3);
    check("R9 R8 no_cross", no_cross, 0);

    // R2: odd reps, exact threshold behaviour (2 of 5 low, 3 of 5 high)
    pulse_start();
    reps = 5;
    run_step(0, 5, 2, 3);
    run_step(4, 5, 3, 2);
    check("R2 3 of 5 high vs 2 of 5 low a", cross_a, 4);
    check("R2 3 of 5 high vs 2 of 5 low b", cross_b, 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule